// File: doc/BRIEF.md
# Triggered Sample Recorder with Serial Dump

This block is an on-chip logic analyzer. It records a vector of internal signals on every clock into a circular sample store. When a single-cycle trigger strobe arrives, it records a fixed number of further samples, then freezes the store. The last few samples taken before the trigger stay in the store as a pre-trigger window.

Once the store is frozen, the block reads it out automatically. It starts at the oldest sample and goes forward in time. Each sample is widened to the next power-of-two bit count and cut into whole bytes. The bytes leave over a transmit-only serial line with a fixed frame of 8 data bits, no parity and 1 stop bit. The bit rate is set by an integer clock divisor, equal to the clock frequency divided by the baud rate and rounded down. When the last byte has gone, the recorder re-arms by itself.

The control state machine has four states. ST_ARMED writes every cycle and waits for the trigger. The trigger moves it to ST_CAPTURE, or straight to ST_SEND when only one post-trigger sample is kept. ST_CAPTURE writes the post-trigger samples and moves to ST_SEND with the last one. ST_SEND hands a byte to the transmitter once the transmitter is free, then moves to ST_WAIT. ST_WAIT waits for the end of the frame. It then goes back to ST_SEND for the next byte, or to ST_ARMED after the final byte.

Top module: `ula_sample_dump`

## Requirements
- R1: The serial line rests at 1. Each byte is framed as one start bit of 0, then 8 data bits least significant bit first, then one stop bit of 1.
- R2: Every bit of a frame, including start and stop, is held for exactly DIVISOR clock cycles.
- R3: While reset is held, and right after it, tx is 1, idle is 1, and sampling and complete are both 0.
- R4: The sample applied in the cycle the trigger is seen is the first post-trigger sample. The frozen store holds the PRE_SAMPLES samples taken in the cycles just before that one, followed by DEPTH-PRE_SAMPLES samples starting at it.
- R5: When DEPTH-PRE_SAMPLES is greater than 1, sampling is 1 from the clock edge that takes the trigger until the edge that writes the final post-trigger sample. It is 0 at all other times.
- R6: complete becomes 1 at the edge that writes the final post-trigger sample. It stays 1 until the last byte of the dump has finished, and is never 1 together with sampling.
- R7: The dump sends the DEPTH stored samples oldest first. Each sample is zero-extended to PAD_W = 2^ceil(log2(SAMPLE_W)) bits and sent as PAD_W/8 bytes (at least one), least significant byte first. With SAMPLE_W=12, each sample is two bytes, and the upper byte carries bits 11:8 in its low nibble with zeros above them.
- R8: A trigger seen while capturing or dumping has no effect. Capture length, status timing and the bytes sent are unchanged, and the transmitter starts frames only while complete is 1.
- R9: idle is 1 exactly when the transmitter is not sending a frame. It is 0 from the edge that starts a frame until the stop bit ends.
- R10: After the final byte, the block returns to ST_ARMED with complete at 0. A later trigger starts a new capture and dump that work in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and serial clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_in | input | SAMPLE_W | Signal vector to record |
| trigger | input | 1 | Single-cycle capture start strobe |
| sampling | output | 1 | High while post-trigger samples are being written |
| complete | output | 1 | High from a full store until the dump ends |
| idle | output | 1 | Transmitter free and able to take a byte |
| tx | output | 1 | Serial transmit line, 8N1 |

## Verification
The capture-and-dump cycle runs several times in a row. Each run uses a different sample pattern: an arithmetic ramp, alternating 0xAAA/0x555, a walking one, and an inverted product. Each run also uses a different delay from re-arming to the trigger. The ramp shows whether the window is ordered and aligned to the trigger: a store that starts one slot off shows up at once. The alternating and walking patterns show bit order and byte order within the frame, and they would expose a non-zero padding nibble. Changing the delay moves the trigger to different store positions, so it tests wrap-around, and the runs that follow one another test re-arming. Extra triggers are sent in the middle of capture and in the middle of the dump, and the status timing and decoded bytes must not change.

// File: rtl/ula_pkg.sv
package ula_pkg;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_SEND    = 2'd2,
        ST_WAIT    = 2'd3
    } ula_state_e;

    localparam int unsigned FRAME_BITS = 10;

endpackage

// File: rtl/ula_ringbuf.sv
module ula_ringbuf #(
    parameter int unsigned WIDTH = 12,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [AW-1:0]    wr_addr,
    output logic [WIDTH-1:0] rd_data
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    head;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else if (wr_en) begin
            head <= (head == LAST_SLOT) ? '0 : head + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[head] <= wr_data;
        end
    end

    assign wr_addr = head;
    assign rd_data = store[rd_addr];

endmodule

// File: rtl/ula_uart_tx.sv
module ula_uart_tx #(
    parameter int unsigned DIVISOR = 434
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       tx,
    output logic       busy,
    output logic       done
);

    import ula_pkg::*;

    localparam int unsigned DIVW = (DIVISOR > 1) ? $clog2(DIVISOR) : 1;
    localparam logic [DIVW-1:0] DIV_LAST = DIVW'(DIVISOR - 1);
    localparam logic [3:0] BIT_LAST = 4'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [DIVW-1:0]       divcnt;
    logic [3:0]            bitcnt;
    logic                  div_wrap;

    assign div_wrap = (divcnt == DIV_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '1;
            divcnt <= '0;
            bitcnt <= '0;
            busy   <= 1'b0;
        end else if (start && !busy) begin
            shreg  <= {1'b1, data, 1'b0};
            divcnt <= '0;
            bitcnt <= '0;
            busy   <= 1'b1;
        end else if (busy) begin
            if (div_wrap) begin
                divcnt <= '0;
                shreg  <= {1'b1, shreg[FRAME_BITS-1:1]};
                if (bitcnt == BIT_LAST) begin
                    busy <= 1'b0;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end else begin
                divcnt <= divcnt + 1'b1;
            end
        end
    end

    assign tx   = busy ? shreg[0] : 1'b1;
    assign done = busy && div_wrap && (bitcnt == BIT_LAST);

endmodule

// File: rtl/ula_sample_dump.sv
module ula_sample_dump #(
    parameter int unsigned SAMPLE_W    = 12,
    parameter int unsigned DEPTH       = 32,
    parameter int unsigned PRE_SAMPLES = 1,
    parameter int unsigned DIVISOR     = 434
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                trigger,
    output logic                sampling,
    output logic                complete,
    output logic                idle,
    output logic                tx
);

    import ula_pkg::*;

    localparam int unsigned PAD_W   = 1 << $clog2(SAMPLE_W);
    localparam int unsigned N_BYTES = (PAD_W + 7) / 8;
    localparam int unsigned BUF_W   = N_BYTES * 8;
    localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned BW      = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
    localparam int unsigned POST    = DEPTH - PRE_SAMPLES;
    localparam int unsigned CW      = $clog2(DEPTH + 1);

    localparam logic [CW-1:0] POST_LAST = CW'(POST - 1);
    localparam logic [AW-1:0] SMP_LAST  = AW'(DEPTH - 1);
    localparam logic [BW-1:0] BYTE_LAST = BW'(N_BYTES - 1);
    localparam logic [AW:0]   DEPTH_X   = (AW + 1)'(DEPTH);

    ula_state_e state, state_nx;

    logic [CW-1:0]       post_cnt;
    logic [AW-1:0]       smp_cnt;
    logic [BW-1:0]       byte_idx;
    logic                wr_en;
    logic [AW-1:0]       wr_addr;
    logic [AW-1:0]       rd_addr;
    logic [AW:0]         rd_sum;
    logic [SAMPLE_W-1:0] rd_data;
    logic [BUF_W-1:0]    rd_wide;
    logic [7:0]          byte_lane [N_BYTES];
    logic [7:0]          tx_byte;
    logic                tx_start;
    logic                tx_busy;
    logic                tx_done;
    logic                last_byte;

    // Sample store: frozen while dumping, so wr_addr then points at the oldest entry.
    ula_ringbuf #(
        .WIDTH (SAMPLE_W),
        .DEPTH (DEPTH)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (sample_in),
        .rd_addr (rd_addr),
        .wr_addr (wr_addr),
        .rd_data (rd_data)
    );

    ula_uart_tx #(
        .DIVISOR (DIVISOR)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .data  (tx_byte),
        .tx    (tx),
        .busy  (tx_busy),
        .done  (tx_done)
    );

    // Read address: oldest slot plus the number of samples already sent, modulo DEPTH.
    assign rd_sum  = {1'b0, wr_addr} + {1'b0, smp_cnt};
    assign rd_addr = (rd_sum >= DEPTH_X) ? AW'(rd_sum - DEPTH_X) : rd_sum[AW-1:0];

    // Zero-extend to the padded width and split into byte lanes.
    assign rd_wide = BUF_W'(rd_data);

    for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
        assign byte_lane[g] = rd_wide[g*8 +: 8];
    end

    assign tx_byte   = byte_lane[byte_idx];
    assign last_byte = (byte_idx == BYTE_LAST) && (smp_cnt == SMP_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ARMED;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED: begin
                if (trigger) begin
                    state_nx = (POST == 1) ? ST_SEND : ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                if (post_cnt == POST_LAST) begin
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                if (!tx_busy) begin
                    state_nx = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tx_done) begin
                    state_nx = last_byte ? ST_ARMED : ST_SEND;
                end
            end
            default: state_nx = ST_ARMED;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        wr_en    = 1'b0;
        tx_start = 1'b0;
        sampling = 1'b0;
        complete = 1'b0;
        unique case (state)
            ST_ARMED:   wr_en = 1'b1;
            ST_CAPTURE: begin
                wr_en    = 1'b1;
                sampling = 1'b1;
            end
            ST_SEND: begin
                complete = 1'b1;
                tx_start = !tx_busy;
            end
            ST_WAIT:    complete = 1'b1;
            default: ;
        endcase
    end

    assign idle = !tx_busy;

    // Counters for capture length and dump position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_cnt <= '0;
            smp_cnt  <= '0;
            byte_idx <= '0;
        end else begin
            unique case (state)
                ST_ARMED: begin
                    smp_cnt  <= '0;
                    byte_idx <= '0;
                    post_cnt <= trigger ? CW'(1) : '0;
                end
                ST_CAPTURE: post_cnt <= post_cnt + 1'b1;
                ST_SEND: ;
                ST_WAIT: begin
                    if (tx_done) begin
                        if (byte_idx == BYTE_LAST) begin
                            byte_idx <= '0;
                            smp_cnt  <= smp_cnt + 1'b1;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ula_sample_dump_chk.sv
module ula_sample_dump_chk (
    input logic clk,
    input logic rst_n,
    input logic trigger,
    input logic sampling,
    input logic complete,
    input logic idle,
    input logic tx
);

    // R9 / R1: a free transmitter holds the line at 1
    p_idle_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> tx);

    // R6: the two status flags never overlap
    p_status_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sampling && complete));

    // R5: capture only begins after a trigger
    p_sampling_from_trigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sampling) |-> $past(trigger));

    // R6: a full store follows capture or a one-sample post window
    p_complete_after_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(complete) |-> ($past(sampling) || $past(trigger)));

    // R8: frames start only during a dump
    p_tx_only_in_dump_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> complete);

    // R8: a trigger during capture does not abort it
    p_capture_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && trigger) |=> (sampling || complete));

endmodule

bind ula_sample_dump ula_sample_dump_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trigger  (trigger),
    .sampling (sampling),
    .complete (complete),
    .idle     (idle),
    .tx       (tx)
);

// File: tb/ula_sample_dump_test.sv
module ula_sample_dump_test;

    localparam int SW = 12;
    localparam int DP = 8;
    localparam int PR = 3;
    localparam int DV = 4;
    localparam int NB = 2;

    // Table: {cycles armed before trigger, sample pattern}
    localparam int NRUN = 4;
    localparam int TBL [NRUN][2] = '{'{12, 0}, '{20, 1}, '{11, 2}, '{29, 3}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trigger = 1'b0;
    logic [SW-1:0] sample_in;
    logic          sampling, complete, idle, tx;

    int cyc = 0;
    int pat_sel = 0;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [SW-1:0] pat(int sel, int c);
        case (sel)
            0:       return SW'(c * 37 + 5);
            1:       return c[0] ? 12'hAAA : 12'h555;
            2:       return 12'h001 << (c % 12);
            default: return SW'(~(c * 113));
        endcase
    endfunction

    assign sample_in = pat(pat_sel, cyc);

    ula_sample_dump #(
        .SAMPLE_W    (SW),
        .DEPTH       (DP),
        .PRE_SAMPLES (PR),
        .DIVISOR     (DV)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_in (sample_in),
        .trigger   (trigger),
        .sampling  (sampling),
        .complete  (complete),
        .idle      (idle),
        .tx        (tx)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Mid-bit sampling receiver; a wrong bit length drifts out of the data bits.
    task automatic rx_byte(output logic [7:0] b, output logic st, output logic sp,
                           output logic busy_seen);
        do @(negedge clk); while (tx !== 1'b0);
        busy_seen = !idle;
        repeat (DV / 2) @(negedge clk);
        st = tx;
        for (int i = 0; i < 8; i++) begin
            repeat (DV) @(negedge clk);
            b[i] = tx;
        end
        repeat (DV) @(negedge clk);
        sp = tx;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not end actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int t0;
        logic [7:0] b;
        logic st, sp, bz;
        logic [SW-1:0] s;
        logic [15:0] wide;
        logic [7:0] expb;

        // R3: reset state
        repeat (3) @(negedge clk);
        chk(tx == 1'b1, "R3", "tx in reset", tx, 1);
        chk(idle == 1'b1, "R3", "idle in reset", idle, 1);
        chk(sampling == 1'b0, "R3", "sampling in reset", sampling, 0);
        chk(complete == 1'b0, "R3", "complete in reset", complete, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx == 1'b1 && idle == 1'b1, "R3", "line after reset", {tx, idle}, 2'b11);

        for (int e = 0; e < NRUN; e++) begin
            pat_sel = TBL[e][1];
            repeat (TBL[e][0]) @(negedge clk);
            chk(!sampling && !complete, "R10", "armed before trigger",
                {sampling, complete}, 0);
            trigger = 1'b1;
            t0 = cyc;
            @(negedge clk);
            trigger = 1'b0;
            chk(sampling == 1'b1, "R5", "sampling after trigger edge", sampling, 1);
            @(negedge clk);
            trigger = 1'b1;              // R8: ignored during capture
            @(negedge clk);
            trigger = 1'b0;
            @(negedge clk);
            chk(sampling == 1'b1 && complete == 1'b0, "R5", "still capturing",
                {sampling, complete}, 2'b10);
            @(negedge clk);
            chk(sampling == 1'b0 && complete == 1'b1, "R6", "full after last write (R8 capture)",
                {sampling, complete}, 2'b01);

            for (int k = 0; k < DP; k++) begin
                s = pat(pat_sel, t0 - PR + k);
                wide = 16'(s);
                for (int j = 0; j < NB; j++) begin
                    rx_byte(b, st, sp, bz);
                    expb = (j == 0) ? wide[7:0] : wide[15:8];
                    if (k == 0 && j == 0) begin
                        chk(bz == 1'b1, "R9", "idle low in frame", !bz, 0);
                        chk(complete == 1'b1, "R6", "complete during dump", complete, 1);
                        @(negedge clk);
                        trigger = 1'b1;  // R8: ignored during dump
                        @(negedge clk);
                        trigger = 1'b0;
                    end
                    chk(st == 1'b0 && sp == 1'b1, "R1", "start/stop bits", {st, sp}, 2'b01);
                    chk(b == expb, "R7", $sformatf("run %0d sample %0d byte %0d (R2 R4 R8)", e, k, j),
                        b, expb);
                end
            end

            repeat (DV + 2) @(negedge clk);
            chk(complete == 1'b0 && idle == 1'b1 && tx == 1'b1, "R10", "rearmed after dump",
                {complete, idle, tx}, 3'b011);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule